// File: doc/BRIEF.md
# Manchester Line Receive Sampler

This block watches one receive line of a twisted-pair 10 Mb/s link and turns a Manchester-coded burst into a stream of decoded bytes. The line is first synchronised. The block then wakes on any transition. It throws away wake-ups caused by lone link test pulses. It locks its sampling phase to a falling edge of the 5 MHz preamble square wave and takes one sample in the middle of each 50 ns half-bit. From each pair of samples it keeps the second one as the data bit. Bits are packed first-received-first into bytes. Each byte goes out with a valid strobe, and the first output of a burst carries a start marker.

A burst ends when three samples in a row are equal. Three highs mean the idle-high end-of-transmission signal. Three lows mean a cut-off transmission. A partly filled last byte is then pushed out, left-aligned, together with its bit count. A one-cycle end marker follows. A length ceiling stops runaway bursts and flags them as errors. The block does not search for the frame delimiter, check the CRC, or track link integrity.

All timing constants are counted in clock cycles. They are chosen for an 80 MHz clock: a half-bit is 4 cycles, the phase offset is 6 cycles, and the quiet limit is 9 cycles.

Top module: `lrx_sampler`

## Requirements
- R1: The line passes through a two-stage synchroniser. While the line shows no transition, no output of any kind is produced (`out_valid`, `out_eof` stay 0).
- R2: After a wake-up edge, if the line then stays low for QUIET_TICKS (9) consecutive cycles before it goes high again, the event is taken as a link test pulse: no output is produced and the block returns to waiting.
- R3: After a low interval shorter than QUIET_TICKS that is followed by a high, the next falling edge sets the phase. The first sample is taken OFFSET_TICKS (6) cycles after that edge is seen. A burst that starts from an idle-low line with a 1,0,1,0,... preamble therefore decodes starting at the fifth preamble bit (a 1).
- R4: Samples are spaced HALF_TICKS (4) cycles apart and taken as pairs (first half, second half). The second sample of a pair is the data bit. A pair whose two samples are equal yields no bit.
- R5: Eight decoded bits form a byte, with the first-received bit in `out_byte[7]` and `out_bits` = 8. The first output of a burst has `out_sof` = 1, and no other output does.
- R6: Three consecutive high samples end the burst.
- R7: Three consecutive low samples end the burst.
- R8: If bits remain at the end of a burst, they are output left-aligned (the first bit in bit 7), with `out_bits` = 1..7, and `out_eof` is high the next cycle. Otherwise `out_eof` is high the cycle after the ending sample. `out_eof` is never high together with `out_valid`, and is high for one cycle per burst.
- R9: If a byte completes after MAX_BYTES bytes have already been output, that byte is dropped, the burst ends, and `out_eof` is raised together with `out_err` = 1. `out_err` is 0 on every other end marker.
- R10: After a burst ends, no new burst can start until the line has been free of transitions for QUIET_TICKS cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock (80 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| rx_line | input | 1 | Asynchronous receive line level |
| out_valid | output | 1 | A decoded byte is on `out_byte` this cycle |
| out_byte | output | 8 | Decoded byte, first-received bit in bit 7 |
| out_bits | output | 4 | Number of valid bits in `out_byte` (8, or 1..7 for a final partial byte) |
| out_sof | output | 1 | Marks the first output of a burst |
| out_eof | output | 1 | One-cycle end-of-burst marker |
| out_err | output | 1 | Length ceiling exceeded; only with `out_eof` |

## Verification
The two functions that can fall on the same sample are completing a byte and hitting the length ceiling. The sample that finishes byte MAX_BYTES+1 must both drop that byte and end the burst. This case is provoked by overriding MAX_BYTES to 6 and sending a burst that decodes to more than six full bytes while the line keeps toggling afterwards. It is judged by checking that exactly six bytes arrive, followed by a single end marker with the error flag set. No second burst may start from the remaining transitions. The sequencing between a partial-byte flush and the end marker is judged by the cycle at which each is observed.

// File: rtl/lrx_pkg.sv
package lrx_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_DROP,
        PH_QUIET,
        PH_HUNT,
        PH_ALIGN,
        PH_RUN,
        PH_REST
    } ph_state_e;

    typedef struct packed {
        logic       valid;
        logic [7:0] data;
        logic [3:0] nbits;
        logic       sof;
        logic       eof;
        logic       err;
    } rx_out_t;

    // Move the n youngest bits of v to the top of the byte.
    function automatic logic [7:0] left_align(input logic [7:0] v, input logic [3:0] n);
        logic [3:0] amt;
        amt = 4'd8 - n;
        return v << amt;
    endfunction

endpackage

// File: rtl/lrx_sync.sv
module lrx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic level,
    output logic edge_seen
);
    logic [STAGES-1:0] chain;
    logic              last;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            last  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], din};
            last  <= chain[STAGES-1];
        end
    end

    assign level     = chain[STAGES-1];
    assign edge_seen = level ^ last;
endmodule

// File: rtl/lrx_phase.sv
module lrx_phase
    import lrx_pkg::*;
#(
    parameter int HALF_TICKS   = 4,
    parameter int OFFSET_TICKS = 6,
    parameter int QUIET_TICKS  = 9
) (
    input  logic clk,
    input  logic rst,
    input  logic level,
    input  logic edge_seen,
    input  logic done,
    output logic start,
    output logic stb,
    output logic smp
);
    localparam int CMAX = (QUIET_TICKS > OFFSET_TICKS) ? QUIET_TICKS : OFFSET_TICKS;
    localparam int CW   = $clog2(CMAX + 1);
    localparam logic [CW-1:0] Q_LAST = CW'(QUIET_TICKS - 1);
    localparam logic [CW-1:0] O_END  = CW'(OFFSET_TICKS);
    localparam logic [CW-1:0] H_END  = CW'(HALF_TICKS);
    localparam logic [CW-1:0] C_ONE  = CW'(1);

    ph_state_e     st;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= PH_IDLE;
            cnt <= '0;
        end else begin
            case (st)
                PH_IDLE:  if (edge_seen) st <= PH_DROP;
                PH_DROP:  if (!level) begin st <= PH_QUIET; cnt <= C_ONE; end
                PH_QUIET: begin
                    if (level)              st  <= PH_HUNT;
                    else if (cnt == Q_LAST) st  <= PH_IDLE;
                    else                    cnt <= cnt + C_ONE;
                end
                PH_HUNT:  if (!level) begin st <= PH_ALIGN; cnt <= C_ONE; end
                PH_ALIGN: begin
                    if (cnt == O_END) begin st <= PH_RUN; cnt <= C_ONE; end
                    else cnt <= cnt + C_ONE;
                end
                PH_RUN: begin
                    if (done)              begin st <= PH_REST; cnt <= '0; end
                    else if (cnt == H_END) cnt <= C_ONE;
                    else                   cnt <= cnt + C_ONE;
                end
                PH_REST: begin
                    if (edge_seen)          cnt <= '0;
                    else if (cnt == Q_LAST) st  <= PH_IDLE;
                    else                    cnt <= cnt + C_ONE;
                end
                default: st <= PH_IDLE;
            endcase
        end
    end

    assign start = (st == PH_HUNT) && !level;
    assign stb   = ((st == PH_ALIGN) && (cnt == O_END)) ||
                   ((st == PH_RUN) && (cnt == H_END) && !done);
    assign smp   = level;

    // Cycles since the previous strobe, for the spacing check.
    logic [CW-1:0] gap;
    always_ff @(posedge clk) begin
        if (rst)                            gap <= '0;
        else if (stb)                       gap <= C_ONE;
        else if (gap != CW'(CMAX))          gap <= gap + C_ONE;
    end

    p_sample_spacing_r4: assert property (@(posedge clk) disable iff (rst)
        (stb && st == PH_RUN) |-> (gap == H_END));

    p_no_strobe_when_idle_r1: assert property (@(posedge clk) disable iff (rst)
        (st == PH_IDLE) |=> !stb);
endmodule

// File: rtl/lrx_decode.sv
module lrx_decode
    import lrx_pkg::*;
#(
    parameter int MAX_BYTES = 1600
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    input  logic    stb,
    input  logic    smp,
    output logic    done,
    output rx_out_t q
);
    localparam int BCW = $clog2(MAX_BYTES + 1);

    logic           half, h1, last, first, eof_pend;
    logic [1:0]     run, run_n;
    logic [7:0]     sh, sh_n;
    logic [3:0]     nb;
    logic [BCW-1:0] bytes;
    logic           term, bit_ok, limit;

    always_comb begin
        run_n  = (run != 2'd0 && smp == last) ? run + 2'd1 : 2'd1;
        term   = (run_n == 2'd3);
        bit_ok = half && (smp != h1);
        sh_n   = {sh[6:0], smp};
        limit  = bit_ok && (nb == 4'd7) && (bytes == BCW'(MAX_BYTES));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q        <= '0;
            half     <= 1'b0;
            h1       <= 1'b0;
            last     <= 1'b0;
            run      <= '0;
            sh       <= '0;
            nb       <= '0;
            bytes    <= '0;
            first    <= 1'b1;
            eof_pend <= 1'b0;
            done     <= 1'b0;
        end else begin
            q.valid  <= 1'b0;
            q.sof    <= 1'b0;
            q.eof    <= eof_pend;
            q.err    <= 1'b0;
            eof_pend <= 1'b0;
            done     <= 1'b0;
            if (start) begin
                half  <= 1'b0;
                run   <= '0;
                nb    <= '0;
                bytes <= '0;
                first <= 1'b1;
            end else if (stb) begin
                last <= smp;
                run  <= run_n;
                if (term || limit) begin
                    done <= 1'b1;
                    if (limit) begin
                        q.eof <= 1'b1;
                        q.err <= 1'b1;
                    end else if (nb != 4'd0) begin
                        q.valid  <= 1'b1;
                        q.data   <= left_align(sh, nb);
                        q.nbits  <= nb;
                        q.sof    <= first;
                        first    <= 1'b0;
                        eof_pend <= 1'b1;
                    end else if (!first) begin
                        q.eof <= 1'b1;
                    end
                end else begin
                    half <= ~half;
                    if (!half) h1 <= smp;
                    if (bit_ok) begin
                        if (nb == 4'd7) begin
                            q.valid <= 1'b1;
                            q.data  <= sh_n;
                            q.nbits <= 4'd8;
                            q.sof   <= first;
                            first   <= 1'b0;
                            nb      <= '0;
                            bytes   <= bytes + BCW'(1);
                        end else begin
                            sh <= sh_n;
                            nb <= nb + 4'd1;
                        end
                    end
                end
            end
        end
    end

    p_sof_needs_valid_r5: assert property (@(posedge clk) disable iff (rst)
        q.sof |-> q.valid);
    p_eof_alone_r8: assert property (@(posedge clk) disable iff (rst)
        q.eof |-> !q.valid);
    p_partial_then_eof_r8: assert property (@(posedge clk) disable iff (rst)
        (q.valid && q.nbits != 4'd8) |=> q.eof);
    p_eof_single_r8: assert property (@(posedge clk) disable iff (rst)
        q.eof |=> !q.eof);
    p_err_with_eof_r9: assert property (@(posedge clk) disable iff (rst)
        q.err |-> q.eof);
    p_byte_ceiling_r9: assert property (@(posedge clk) disable iff (rst)
        bytes <= BCW'(MAX_BYTES));
    p_nbits_range_r5: assert property (@(posedge clk) disable iff (rst)
        q.valid |-> (q.nbits != 4'd0 && q.nbits <= 4'd8));
endmodule

// File: rtl/lrx_sampler.sv
module lrx_sampler
    import lrx_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter int HALF_TICKS   = 4,
    parameter int OFFSET_TICKS = 6,
    parameter int QUIET_TICKS  = 9,
    parameter int MAX_BYTES    = 1600
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_line,
    output logic       out_valid,
    output logic [7:0] out_byte,
    output logic [3:0] out_bits,
    output logic       out_sof,
    output logic       out_eof,
    output logic       out_err
);
    logic    level, edge_seen, start, stb, smp, done;
    rx_out_t q;

    lrx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .din(rx_line),
        .level(level), .edge_seen(edge_seen)
    );

    lrx_phase #(
        .HALF_TICKS(HALF_TICKS), .OFFSET_TICKS(OFFSET_TICKS), .QUIET_TICKS(QUIET_TICKS)
    ) u_phase (
        .clk(clk), .rst(rst), .level(level), .edge_seen(edge_seen),
        .done(done), .start(start), .stb(stb), .smp(smp)
    );

    lrx_decode #(.MAX_BYTES(MAX_BYTES)) u_dec (
        .clk(clk), .rst(rst), .start(start), .stb(stb), .smp(smp),
        .done(done), .q(q)
    );

    assign out_valid = q.valid;
    assign out_byte  = q.data;
    assign out_bits  = q.nbits;
    assign out_sof   = q.sof;
    assign out_eof   = q.eof;
    assign out_err   = q.err;
endmodule

// File: tb/sim_lrx_sampler.sv
module sim_lrx_sampler;
    localparam int MAXB = 6;
    localparam int PRE  = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx  = 1'b0;
    logic       out_valid, out_sof, out_eof, out_err;
    logic [7:0] out_byte;
    logic [3:0] out_bits;

    always #4 clk = ~clk;

    lrx_sampler #(.MAX_BYTES(MAXB)) u0 (
        .clk(clk), .rst(rst), .rx_line(rx),
        .out_valid(out_valid), .out_byte(out_byte), .out_bits(out_bits),
        .out_sof(out_sof), .out_eof(out_eof), .out_err(out_err)
    );

    int nchk = 0, nfail = 0, cyc = 0;
    int rcnt = 0, neof = 0, eof_cyc = 0;
    logic eof_err = 1'b0;
    logic [7:0] r_data [0:63];
    int r_bits [0:63];
    int r_sof  [0:63];
    int r_cyc  [0:63];
    int pay    [0:63];
    int ebits  [0:255];
    int en = 0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) if (!rst) begin
        if (out_valid) begin
            if (rcnt < 64) begin
                r_data[rcnt] = out_byte;
                r_bits[rcnt] = int'(out_bits);
                r_sof[rcnt]  = int'(out_sof);
                r_cyc[rcnt]  = cyc;
            end
            rcnt++;
        end
        if (out_eof) begin
            neof++;
            eof_err = out_err;
            eof_cyc = cyc;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic hold(input logic v, input int n);
        rx = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_rec();
        rcnt = 0; neof = 0; eof_err = 1'b0;
    endtask

    function automatic int pack_at(input int s, input int n);
        int v = 0;
        for (int i = 0; i < 8; i++)
            if (i < n) v = v | (ebits[s+i] << (7 - i));
        return v;
    endfunction

    // Codes in pay: 0/1 = data bit, 2 = a half-pair of two lows (no bit).
    task automatic send_frame(input int npay, input int mode, input string tag);
        int nfull, rem, ncnt, experr;
        clear_rec();
        hold(1'b0, 20);
        for (int i = 0; i < PRE; i++) begin
            hold((i % 2 == 0) ? 1'b0 : 1'b1, 4);
            hold((i % 2 == 0) ? 1'b1 : 1'b0, 4);
        end
        for (int i = 0; i < npay; i++) begin
            if (pay[i] == 2) begin hold(1'b0, 4); hold(1'b0, 4); end
            else begin hold(pay[i] == 0, 4); hold(pay[i] == 1, 4); end
        end
        if (mode == 0) begin hold(1'b1, 32); hold(1'b0, 40); end
        else hold(1'b0, 60);
        // expected stream: preamble from the fifth bit, then the payload
        en = 0;
        for (int i = 4; i < PRE; i++) begin ebits[en] = (i % 2 == 0) ? 1 : 0; en++; end
        for (int i = 0; i < npay; i++) if (pay[i] != 2) begin ebits[en] = pay[i]; en++; end
        nfull = en / 8;
        rem   = en % 8;
        if (nfull > MAXB) begin ncnt = MAXB; rem = 0; experr = 1; end
        else begin ncnt = nfull + ((rem > 0) ? 1 : 0); experr = 0; end
        check({tag, " R5 output count"}, rcnt, ncnt);
        check({tag, (mode == 0) ? " R6 one eof" : " R7 one eof"}, neof, 1);
        check({tag, " R9 err flag"}, int'(eof_err), experr);
        for (int k = 0; k < ncnt && k < 64; k++) begin
            if (k < nfull && k < MAXB) begin
                check({tag, " R5 byte"}, int'(r_data[k]), pack_at(8*k, 8));
                check({tag, " R5 bits"}, r_bits[k], 8);
            end else begin
                check({tag, " R8 partial byte"}, int'(r_data[k]), pack_at(8*k, rem));
                check({tag, " R8 partial bits"}, r_bits[k], rem);
                check({tag, " R8 eof follows partial"}, eof_cyc, r_cyc[k] + 1);
            end
            check({tag, " R5 sof"}, r_sof[k], (k == 0) ? 1 : 0);
        end
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset valid", int'(out_valid), 0);
        check("R1 reset eof", int'(out_eof), 0);
        clear_rec();
        hold(1'b0, 100);
        check("R1 quiet line output", rcnt + neof, 0);

        // link test pulses, directed and random widths
        for (int i = 0; i < 6; i++) begin
            int w = (i == 0) ? 8 : (i == 1) ? 1 : 1 + int'($urandom % 8);
            clear_rec();
            hold(1'b0, 10);
            hold(1'b1, w);
            hold(1'b0, 40);
            check("R2 test pulse silent", rcnt + neof, 0);
        end

        // directed: exactly two full bytes, idle-high end, last bit 0
        pay[0] = 1; pay[1] = 0; pay[2] = 1; pay[3] = 0;
        send_frame(4, 0, "R3 two bytes");
        // directed: ends with bit 1 into idle high
        pay[0] = 1; pay[1] = 1; pay[2] = 0; pay[3] = 1;
        send_frame(4, 0, "R6 last one");
        // directed: truncated low, partial byte of 3 bits
        pay[0] = 1; pay[1] = 1; pay[2] = 0; pay[3] = 0; pay[4] = 1; pay[5] = 0; pay[6] = 0;
        send_frame(7, 1, "R7 truncated");
        // directed: an equal half-pair is skipped
        pay[0] = 1; pay[1] = 1; pay[2] = 2; pay[3] = 0; pay[4] = 0; pay[5] = 1;
        send_frame(6, 0, "R4 equal pair");
        // directed: ceiling reached while the line keeps toggling
        for (int i = 0; i < 60; i++) pay[i] = int'($urandom % 2);
        send_frame(60, 0, "R9 R10 ceiling");

        // random bursts
        for (int f = 0; f < 12; f++) begin
            int n = int'($urandom % 37);
            for (int i = 0; i < n; i++) pay[i] = int'($urandom % 2);
            send_frame(n, int'($urandom % 2), "R4 random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule